// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sets the pace of a successive-approximation converter. A prescaler divides the system clock by a selectable power of two and yields a one-cycle converter clock enable. Software starts a conversion with a one-cycle start pulse. The sequencer waits for the next converter clock, latches the channel, strobes the analog side to sample, and then resolves ten result bits from a comparator input, most significant bit first. It ends the conversion with a one-cycle done strobe that carries the result.

The first conversion after the block is enabled is stretched to let the analog circuitry settle. In free-running mode the sequencer starts each new conversion as soon as the previous one ends. Dropping the enable aborts whatever is in progress.

Top module: `conv_seq`

## Requirements
- R1: While `rst_n` is low, `busy_o`, `sample_o` and `done_o` are 0, and `chan_o` and `result_o` are all zeros.
- R2: The divide ratio is 2 for `div_sel_i` values 0 and 1, and 2^`div_sel_i` for values 2 to 7. The prescaler counter is held at zero while `en_i` is low. With `en_i` high, converter clocks fall on system cycles div, 2·div, and so on after enable.
- R3: A `start_i` pulse while `en_i` is high and the block is idle makes `busy_o` read 1 from the next cycle. `busy_o` stays 1 until the conversion completes. A `start_i` pulse while `en_i` is low is ignored.
- R4: A conversion begins on the first converter clock after the start. In the cycle after that converter clock, `sample_o` is 1 for exactly one cycle.
- R5: The first conversion after `en_i` rises lasts 25 converter clocks. Every later conversion lasts 13. The number of system cycles from the `sample_o` pulse to the `done_o` pulse is therefore (length−1)·div.
- R6: `chan_o` takes the value of `chan_i` on the converter clock that begins a conversion. Changes to `chan_i` during a conversion do not alter `chan_o` until the next conversion begins.
- R7: With `free_run_i` high, the first conversion still needs a `start_i` pulse. After that, each conversion begins on the next converter clock after the previous one ends, so `busy_o` stays 1 and done pulses repeat every 13·div cycles.
- R8: Result bit 9−j takes the value of `cmp_i` on converter clock L−9+j of a conversion of length L, for j = 0 to 9. Bit 0 is therefore taken on the final clock.
- R9: Clearing `en_i` aborts a conversion in progress. `busy_o` reads 0 on the next cycle, no `done_o` follows, and the next conversion is again a 25-clock first conversion.
- R10: `done_o` is a one-cycle pulse in the cycle after the final converter clock, and `result_o` updates in the same cycle. In single mode, `busy_o` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low holds prescaler and sequencer idle |
| start_i | input | 1 | One-cycle start-conversion write |
| free_run_i | input | 1 | Back-to-back conversion select |
| div_sel_i | input | 3 | Prescale select |
| chan_i | input | CH_W (3) | Requested channel |
| cmp_i | input | 1 | Comparator decision for the current trial bit |
| busy_o | output | 1 | Start-bit readback, high while a conversion is pending or running |
| chan_o | output | CH_W (3) | Channel of the current or last conversion |
| sample_o | output | 1 | One-cycle sample strobe to the analog side |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 10 | Result of the last completed conversion |

## Verification
The hardest situation to reach is an abort that lands late in a long first conversion, followed by a re-enable that must bring the 25-clock length back. Reaching it means waiting through the prescaler and the settling phase at a chosen divide ratio and then dropping `en_i` at a known point. A directed sequence does this by pulling enable low well after the sample strobe and then timing the next conversion. A seeded random phase then toggles enable, start, free-run and the divide select around a bench reference model, so that aborts also land at random points inside free-running runs.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_prescaler.sv
module conv_prescaler #(
  parameter int CNT_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic [SEL_W-1:0] shamt;

  // select 0 behaves as select 1 (divide by two)
  always_comb begin
    shamt = (sel_i == '0) ? SEL_W'(1) : sel_i;
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(shamt));
  end

  always_comb begin
    cnt_d = en_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/conv_sar.sv
module conv_sar #(
  parameter int RES_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] bits_next_o
);
  logic [RES_W-1:0] sar_q;

  always_comb begin
    bits_next_o = sar_q;
    if (step_i) bits_next_o[idx_i] = cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sar_q <= '0;
    else if (step_i) sar_q <= bits_next_o;
  end
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_seq_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int RES_W     = 10,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25,
  parameter int LEN_W     = $clog2(FIRST_LEN + 1),
  parameter int IDX_W     = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             free_run_i,
  input  logic             tick_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [RES_W-1:0] sar_next_i,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam logic [LEN_W-1:0] LEN_N = LEN_W'(NORM_LEN);
  localparam logic [LEN_W-1:0] LEN_F = LEN_W'(FIRST_LEN);
  localparam logic [LEN_W-1:0] BITS_M1 = LEN_W'(RES_W - 1);

  seq_state_e       state_q, state_d;
  logic             first_q, first_d;
  logic [LEN_W-1:0] k_q, k_d, k_inc, len;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic             sample_q, sample_d, done_q, done_d, last;
  logic [RES_W-1:0] res_q, res_d;

  assign len    = first_q ? LEN_F : LEN_N;
  assign k_inc  = k_q + 1'b1;
  assign step_o = (state_q == ST_RUN) && tick_i && (k_inc >= len - BITS_M1);
  assign idx_o  = IDX_W'(len - k_inc);
  assign last   = step_o && (k_inc == len);

  always_comb begin
    state_d  = state_q;
    first_d  = first_q;
    k_d      = k_q;
    chan_d   = chan_q;
    res_d    = res_q;
    sample_d = 1'b0;
    done_d   = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      first_d = 1'b1;
      k_d     = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_WAIT;
        ST_WAIT: if (tick_i) begin
          state_d  = ST_RUN;
          k_d      = LEN_W'(1);
          chan_d   = chan_i;
          sample_d = 1'b1;
        end
        ST_RUN: if (tick_i) begin
          k_d = k_inc;
          if (last) begin
            res_d   = sar_next_i;
            done_d  = 1'b1;
            first_d = 1'b0;
            k_d     = '0;
            state_d = free_run_i ? ST_WAIT : ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      first_q  <= 1'b1;
      k_q      <= '0;
      chan_q   <= '0;
      sample_q <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      state_q  <= state_d;
      first_q  <= first_d;
      k_q      <= k_d;
      chan_q   <= chan_d;
      sample_q <= sample_d;
      done_q   <= done_d;
      res_q    <= res_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign chan_o   = chan_q;
  assign sample_o = sample_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int CH_W      = 3,
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 7,
  parameter int RES_W     = 10,
  parameter int NORM_LEN  = 13,
  parameter int FIRST_LEN = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             free_run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_W);

  logic             tick, step;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] sar_next;

  conv_prescaler #(.CNT_W(CNT_W), .SEL_W(SEL_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_i(div_sel_i), .tick_o(tick)
  );

  conv_sar #(.RES_W(RES_W), .IDX_W(IDX_W)) sar_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .idx_i(idx), .cmp_i(cmp_i),
    .bits_next_o(sar_next)
  );

  conv_ctrl #(
    .CH_W(CH_W), .RES_W(RES_W), .NORM_LEN(NORM_LEN), .FIRST_LEN(FIRST_LEN),
    .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
    .free_run_i(free_run_i), .tick_i(tick), .chan_i(chan_i),
    .sar_next_i(sar_next), .step_o(step), .idx_o(idx), .busy_o(busy_o),
    .chan_o(chan_o), .sample_o(sample_o), .done_o(done_o), .result_o(result_o)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            start_i,
  input logic            free_run_i,
  input logic            busy_o,
  input logic [CH_W-1:0] chan_o,
  input logic            sample_o,
  input logic            done_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && start_i && !busy_o |=> busy_o); // R3
  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_o && !done_o); // R4
  AST_CHAN_ONLY_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (chan_o != $past(chan_o)) |-> sample_o); // R6
  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_o && !done_o && !sample_o); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_SINGLE_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && done_o && !$past(free_run_i) |-> !busy_o); // R10
endmodule

bind conv_seq conv_seq_chk #(.CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
  .free_run_i(free_run_i), .busy_o(busy_o), .chan_o(chan_o),
  .sample_o(sample_o), .done_o(done_o)
);

// File: tb/conv_seq_tb.sv
module conv_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int CH_W  = 3;

  logic clk, rst_n, en_i, start_i, free_run_i, cmp_i;
  logic [2:0] div_sel_i;
  logic [CH_W-1:0] chan_i;
  logic busy_o, sample_o, done_o;
  logic [CH_W-1:0] chan_o;
  logic [9:0] result_o;

  int checks = 0, errors = 0;
  bit stim_done = 0;

  conv_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
    .free_run_i(free_run_i), .div_sel_i(div_sel_i), .chan_i(chan_i),
    .cmp_i(cmp_i), .busy_o(busy_o), .chan_o(chan_o), .sample_o(sample_o),
    .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int div_of(input logic [2:0] s);
    return (s < 2) ? 2 : (1 << s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated per system clock from the requirements
  int m_cnt, m_k, m_len, m_state;
  bit m_first, m_busy, m_sample, m_done;
  logic [CH_W-1:0] m_chan;
  logic [9:0] m_sar, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_k = 0; m_state = 0; m_first = 1; m_busy = 0;
      m_sample = 0; m_done = 0; m_chan = '0; m_sar = '0; m_res = '0;
    end else begin
      automatic int d = div_of(div_sel_i);
      automatic bit tick = en_i && ((m_cnt % d) == d - 1);
      m_sample = 0; m_done = 0;
      if (!en_i) begin
        m_state = 0; m_first = 1; m_k = 0;
      end else if (m_state == 0) begin
        if (start_i) m_state = 1;
      end else if (m_state == 1) begin
        if (tick) begin
          m_state = 2; m_k = 1; m_chan = chan_i; m_sample = 1;
          m_len = m_first ? 25 : 13;
        end
      end else if (tick) begin
        m_k++;
        if (m_k >= m_len - 9) m_sar[m_len - m_k] = cmp_i;
        if (m_k == m_len) begin
          m_res = m_sar; m_done = 1; m_first = 0; m_k = 0;
          m_state = free_run_i ? 1 : 0;
        end
      end
      m_busy = (m_state != 0);
      m_cnt = en_i ? (m_cnt + 1) % 128 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !stim_done) begin
      check(busy_o === m_busy, "R3 busy", busy_o, m_busy);
      check(sample_o === m_sample, "R4 sample", sample_o, m_sample);
      check(done_o === m_done, "R10 done", done_o, m_done);
      check(chan_o === m_chan, "R6 chan", chan_o, m_chan);
      if (m_done) check(result_o === m_res, "R8 result", result_o, m_res);
    end
  end

  always @(negedge clk) cmp_i <= 1'($urandom);

  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic wait_sig(input bit want_sample, output int n);
    n = 0;
    while ((want_sample ? sample_o : done_o) !== 1'b1 && n < 20000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic measure(input int len, input string req);
    automatic int n;
    wait_sig(1, n);
    @(negedge clk);
    wait_sig(0, n);
    check(n + 1 == (len - 1) * div_of(div_sel_i), req, n + 1,
          (len - 1) * div_of(div_sel_i));
  endtask

  initial begin
    automatic int n;
    process::self().srandom(32'h5eed_0c0d);
    rst_n = 0; en_i = 0; start_i = 0; free_run_i = 0; div_sel_i = 0; chan_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o === 0 && sample_o === 0 && done_o === 0, "R1 flags", busy_o, 0);
    check(chan_o === 0 && result_o === 0, "R1 data", result_o, 0);
    rst_n = 1;
    @(negedge clk);
    // R3 start ignored while disabled
    pulse_start();
    check(busy_o === 0, "R3 start while disabled", busy_o, 0);
    // R5 first conversion 25 clocks, R2 divide by 2 for select 0
    en_i = 1; chan_i = 3'd5;
    pulse_start();
    measure(25, "R5 first length div2");
    // R5 normal 13 clocks, R2 divide by 8
    div_sel_i = 3; repeat (2) @(negedge clk);
    pulse_start();
    measure(13, "R2 R5 normal length div8");
    // R6 channel change mid conversion deferred
    div_sel_i = 2; chan_i = 3'd2;
    pulse_start();
    wait_sig(1, n);
    chan_i = 3'd6;
    wait_sig(0, n);
    check(chan_o === 3'd2, "R6 channel held", chan_o, 2);
    // R7 free run, done spacing 13*div with select 1
    div_sel_i = 1; free_run_i = 1;
    @(negedge clk);
    check(busy_o === 0, "R7 free run needs start", busy_o, 0);
    pulse_start();
    wait_sig(0, n); @(negedge clk);
    check(busy_o === 1, "R7 busy stays high", busy_o, 1);
    wait_sig(0, n);
    check(n + 1 == 26, "R7 back to back spacing", n + 1, 26);
    // R9 abort late in a conversion, then 25-clock length re-armed
    free_run_i = 0; div_sel_i = 4;
    @(negedge clk); wait_sig(0, n); @(negedge clk);
    en_i = 0; @(negedge clk); en_i = 1; div_sel_i = 2;
    pulse_start();
    wait_sig(1, n);
    repeat (20 * 4) @(negedge clk);
    en_i = 0; @(negedge clk);
    check(busy_o === 0, "R9 busy cleared", busy_o, 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (done_o) n++; end
    check(n == 0, "R9 no done after abort", n, 0);
    en_i = 1; div_sel_i = 0;
    pulse_start();
    measure(25, "R9 R5 first length re-armed");
    // R8 directed: comparator stuck values handled by model; random phase
    for (int i = 0; i < 40000; i++) begin
      automatic int r = $urandom_range(0, 999);
      if (r < 2) en_i = ~en_i;
      else if (r < 40) start_i = 1;
      else start_i = 0;
      if (r >= 990) free_run_i = ~free_run_i;
      if (r == 500) div_sel_i = 3'($urandom_range(0, 4));
      if (r >= 900 && r < 920) chan_i = CH_W'($urandom);
      if (!en_i && r > 980) en_i = 1;
      @(negedge clk);
    end
    start_i = 0;
    stim_done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule